// File: doc/BRIEF.md
# Two-Bus Coherence Directory Controller

This block sits between two independent processor buses and a single memory port. It keeps the caches of the two processors coherent for one window of line addresses. Each bus presents line-level requests of three kinds:

- a read fill;
- an ownership request, a fill taken with intent to write;
- an eviction write-back.

Requests that fall outside the window go straight to memory. Inside the window, the block looks up a per-line directory that holds the cache state of each processor. It snoops the other bus only when the directory shows that bus owning a dirty copy, or when that copy must be dropped. A dirty line recovered by a snoop is staged in a one-line buffer. From that buffer it is written back to memory and handed to the requester in the same cycle.

Every in-window read fill is answered with the shared flag raised. A cache able to hold lines exclusively is therefore forced into its shared state, and it cannot later move to modified without a visible request.

A processor without snoop hardware can be declared through a parameter. Snoops aimed at that processor become a one-cycle interrupt pulse, which prompts software to flush. The directory is updated on the clock edge that commits each decision, so the next request already sees the new state.

Top module: `cohdir_ctrl`

## Requirements
- R1: A request whose line address lies outside [win_base_i, win_base_i + win_lines_i) goes to memory with no snoop and no shared flag. It leaves the directory untouched. Only windows of at most 2^IW lines are supported.
- R2: After reset, every directory entry holds Invalid for both processors, and ack, snoop, interrupt and memory outputs are low. At no time does the directory show one processor Modified while the other is not Invalid.
- R3: A read (op 0, or the unused code 3) snoops the other bus only when that processor holds the line Modified. The snoop is a fetch, with snp_inv_o low and snp_addr_o set to the line. The snoop holds until the matching snp_ack_i.
- R4: After a fetch snoop, the data returned with snp_ack_i is written to memory (mem_we_o high, same line) and presented to the requester with hit_o. A read that fetches leaves both processors Shared.
- R5: An ownership request (op 1) to a line the other processor holds Shared snoops the other bus with snp_inv_o high, then reads memory. Afterwards the requester is Modified and the other processor Invalid.
- R6: An ownership request to a line the other processor holds Modified snoops with snp_inv_o high, writes the returned data back and hands it over as in R4. It leaves the requester Modified and the other Invalid.
- R7: shared_o is raised with the acknowledge of every in-window read. It is never raised for ownership requests, evictions or out-of-window reads.
- R8: An eviction (op 2) writes the requester's wdata_i to memory and sets that processor's directory state for the line to Invalid, without any snoop.
- R9: When both buses request in the same cycle, bus 0 is served first. Bus 1 is stalled and its decision uses the directory as updated by bus 0.
- R10: For a bus marked in NOSNP, any snoop the block would send to it is replaced by a one-cycle irq_o pulse on that bus together with the requester's acknowledge. No snp_req_o is raised there, the directory is updated as usual and memory is read.
- R11: A request accepted without a snoop is acknowledged in the following cycle. A snooped request is acknowledged in the cycle after snp_ack_i. The acknowledge is a one-cycle pulse that coincides with mem_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base_i | input | AW | First line address of the coherent window |
| win_lines_i | input | IW+1 | Number of lines in the window |
| req_i | input | 2 | Request per bus, held until ack |
| op_i | input | 2x2 | Request kind per bus: 0 read, 1 ownership, 2 eviction, 3 read |
| addr_i | input | 2xAW | Line address per bus |
| wdata_i | input | 2xDW | Eviction data per bus |
| ack_o | output | 2 | One-cycle completion per bus |
| shared_o | output | 2 | Shared response, valid with ack |
| hit_o | output | 2 | Data supplied from snoop-hit buffer, valid with ack |
| hit_data_o | output | DW | Snoop-hit buffer contents |
| snp_req_o | output | 2 | Snoop request to each bus |
| snp_inv_o | output | 2 | Snoop demands invalidation |
| snp_addr_o | output | AW | Snooped line |
| snp_ack_i | input | 2 | Snoop completion from each bus |
| snp_data_i | input | 2xDW | Dirty line returned by a snooped bus |
| irq_o | output | 2 | Interrupt to a bus that cannot be snooped |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | AW | Memory line address |
| mem_wdata_o | output | DW | Memory write data |

## Verification
Two functions can fall in the same cycle: arbitration between the buses, and the directory update committed for the winner. The bench raises both requests on one edge for the same line, an ownership request on bus 0 and a read on bus 1. Bus 0 must be acknowledged alone while bus 1 waits. Bus 1 must then be judged against the updated entry: it should draw a fetch snoop on bus 0, not a plain memory read. Long pseudo-random sequences over a ten-line window are also checked against a directory model held in the bench. Each access is compared for snoop kind, shared flag, hit data and memory traffic.

// File: rtl/cohdir_ctrl.sv
module cohdir_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int IW = 4,
  parameter logic [1:0] NOSNP = 2'b00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        win_base_i,
  input  logic [IW:0]          win_lines_i,
  input  logic [1:0]           req_i,
  input  logic [1:0][1:0]      op_i,
  input  logic [1:0][AW-1:0]   addr_i,
  input  logic [1:0][DW-1:0]   wdata_i,
  output logic [1:0]           ack_o,
  output logic [1:0]           shared_o,
  output logic [1:0]           hit_o,
  output logic [DW-1:0]        hit_data_o,
  output logic [1:0]           snp_req_o,
  output logic [1:0]           snp_inv_o,
  output logic [AW-1:0]        snp_addr_o,
  input  logic [1:0]           snp_ack_i,
  input  logic [1:0][DW-1:0]   snp_data_i,
  output logic [1:0]           irq_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o
);
  localparam int LINES = 1 << IW;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] OP_OWN = 2'd1, OP_EVICT = 2'd2;

  typedef enum logic [1:0] {IDLE, SNP, ACK} phase_t;

  phase_t            ph;
  logic              cur, cur_own, cur_sh, cur_hit, cur_we, cur_irq, cur_fetch;
  logic [AW-1:0]     cur_addr;
  logic [DW-1:0]     hbuf;
  logic [1:0][1:0]   dir [LINES];

  logic            sel, oth;
  logic [AW-1:0]   a, off;
  logic [1:0]      op, so;
  logic [IW-1:0]   idx;
  logic            inwin, rd, own, ev, need, live;

  assign sel   = ~req_i[0];
  assign oth   = ~sel;
  assign a     = addr_i[sel];
  assign op    = op_i[sel];
  assign off   = a - win_base_i;
  assign inwin = (a >= win_base_i) && (off < AW'(win_lines_i)) && (off < AW'(LINES));
  assign idx   = off[IW-1:0];
  assign so    = inwin ? dir[idx][oth] : ST_I;
  assign own   = (op == OP_OWN);
  assign ev    = (op == OP_EVICT);
  assign rd    = !own && !ev;
  assign need  = inwin && ((rd && so == ST_M) || (own && so != ST_I));
  assign live  = need && !NOSNP[oth];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= IDLE;
      cur       <= 1'b0;
      cur_own   <= 1'b0;
      cur_sh    <= 1'b0;
      cur_hit   <= 1'b0;
      cur_we    <= 1'b0;
      cur_irq   <= 1'b0;
      cur_fetch <= 1'b0;
      cur_addr  <= '0;
      hbuf      <= '0;
      for (int i = 0; i < LINES; i++) dir[i] <= '0;
    end else begin
      case (ph)
        IDLE: if (|req_i) begin
          cur       <= sel;
          cur_own   <= own;
          cur_addr  <= a;
          cur_sh    <= inwin && rd;
          cur_hit   <= 1'b0;
          cur_we    <= ev;
          cur_irq   <= need && NOSNP[oth];
          cur_fetch <= need && (so == ST_M);
          hbuf      <= wdata_i[sel];
          ph        <= live ? SNP : ACK;
          if (inwin) begin
            if (ev) dir[idx][sel] <= ST_I;
            else if (own) begin
              dir[idx][sel] <= ST_M;
              dir[idx][oth] <= ST_I;
            end else begin
              dir[idx][sel] <= ST_S;
              if (so == ST_M) dir[idx][oth] <= ST_S;
            end
          end
        end
        SNP: if (snp_ack_i[~cur]) begin
          ph <= ACK;
          if (cur_fetch) begin
            hbuf    <= snp_data_i[~cur];
            cur_hit <= 1'b1;
            cur_we  <= 1'b1;
          end
        end
        default: ph <= IDLE;
      endcase
    end
  end

  logic in_ack, in_snp;
  assign in_ack      = (ph == ACK);
  assign in_snp      = (ph == SNP);
  assign ack_o       = {in_ack && cur, in_ack && !cur};
  assign shared_o    = ack_o & {2{cur_sh}};
  assign hit_o       = ack_o & {2{cur_hit}};
  assign hit_data_o  = hbuf;
  assign snp_req_o   = {in_snp && !cur, in_snp && cur};
  assign snp_inv_o   = snp_req_o & {2{cur_own}};
  assign snp_addr_o  = cur_addr;
  assign irq_o       = {in_ack && cur_irq && !cur, in_ack && cur_irq && cur};
  assign mem_req_o   = in_ack;
  assign mem_we_o    = in_ack && cur_we;
  assign mem_addr_o  = cur_addr;
  assign mem_wdata_o = hbuf;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    p_single_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(dir[g][0] == ST_M && dir[g][1] != ST_I) && !(dir[g][1] == ST_M && dir[g][0] != ST_I)
      && dir[g][0] != 2'd3 && dir[g][1] != 2'd3)
      else $error("directory single-writer rule broken");
  end

  for (genvar k = 0; k < 2; k++) begin : g_bus
    p_snp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      snp_req_o[k] && !snp_ack_i[k] |=> snp_req_o[k] && $stable(snp_addr_o))
      else $error("snoop dropped before ack");
    p_hit_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o[k] |-> $past(snp_req_o[1-k] && snp_ack_i[1-k]))
      else $error("hit data without snoop");
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o[k] |=> !ack_o[k])
      else $error("ack longer than one cycle");
    if (NOSNP[k]) begin : g_ns
      p_no_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_req_o[k])
        else $error("snoop sent to unsnoopable bus");
    end
  end

  p_hit_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |hit_o |-> mem_req_o && mem_we_o && mem_wdata_o == hit_data_o)
    else $error("snoop hit not written back");
endmodule

// File: tb/cohdir_ctrl_tb.sv
module cohdir_ctrl_tb_top;
  localparam logic [7:0] BASE = 8'h40;
  localparam int NL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]      req = '0;
  logic [1:0][1:0] op = '0;
  logic [1:0][7:0] addr = '0, wd = '0, sdat = '0;
  logic [1:0]      sack = '0;

  logic [1:0] i_ack, i_sh, i_hit, i_sreq, i_sinv, i_irq, n_ack, n_sh, n_hit, n_sreq, n_sinv, n_irq;
  logic [7:0] i_hd, i_saddr, i_maddr, i_mwd, n_hd, n_saddr, n_maddr, n_mwd;
  logic       i_mreq, i_mwe, n_mreq, n_mwe;

  cohdir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .win_base_i(BASE), .win_lines_i(5'(NL)),
    .req_i(req), .op_i(op), .addr_i(addr), .wdata_i(wd),
    .ack_o(i_ack), .shared_o(i_sh), .hit_o(i_hit), .hit_data_o(i_hd),
    .snp_req_o(i_sreq), .snp_inv_o(i_sinv), .snp_addr_o(i_saddr),
    .snp_ack_i(sack), .snp_data_i(sdat), .irq_o(i_irq),
    .mem_req_o(i_mreq), .mem_we_o(i_mwe), .mem_addr_o(i_maddr), .mem_wdata_o(i_mwd));

  cohdir_ctrl #(.NOSNP(2'b10)) dut_n (
    .clk(clk), .rst_n(rst_n), .win_base_i(BASE), .win_lines_i(5'(NL)),
    .req_i(req), .op_i(op), .addr_i(addr), .wdata_i(wd),
    .ack_o(n_ack), .shared_o(n_sh), .hit_o(n_hit), .hit_data_o(n_hd),
    .snp_req_o(n_sreq), .snp_inv_o(n_sinv), .snp_addr_o(n_saddr),
    .snp_ack_i(sack), .snp_data_i(sdat), .irq_o(n_irq),
    .mem_req_o(n_mreq), .mem_we_o(n_mwe), .mem_addr_o(n_maddr), .mem_wdata_o(n_mwd));

  bit use_n = 1'b0;
  wire [1:0] ack  = use_n ? n_ack  : i_ack;
  wire [1:0] sh   = use_n ? n_sh   : i_sh;
  wire [1:0] hit  = use_n ? n_hit  : i_hit;
  wire [1:0] sreq = use_n ? n_sreq : i_sreq;
  wire [1:0] sinv = use_n ? n_sinv : i_sinv;
  wire [1:0] irq  = use_n ? n_irq  : i_irq;
  wire [7:0] hd   = use_n ? n_hd   : i_hd;
  wire [7:0] sadr = use_n ? n_saddr : i_saddr;
  wire [7:0] madr = use_n ? n_maddr : i_maddr;
  wire [7:0] mwd  = use_n ? n_mwd  : i_mwd;
  wire       mreq = use_n ? n_mreq : i_mreq;
  wire       mwe  = use_n ? n_mwe  : i_mwe;

  logic [1:0] mdl [16][2];
  int checks = 0, fails = 0;
  logic [31:0] rnd = 32'h1234_5678;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; sack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin mdl[i][0] = 2'd0; mdl[i][1] = 2'd0; end
    @(negedge clk);
    chk("R2 reset ack", {30'd0, ack}, 0);
    chk("R2 reset snoop", {30'd0, sreq}, 0);
    chk("R2 reset mem", {31'd0, mreq}, 0);
    chk("R2 reset irq", {30'd0, irq}, 0);
  endtask

  task automatic txn(int b, logic [1:0] o, logic [7:0] a, logic [7:0] w, logic [7:0] s);
    int ot = 1 - b;
    int ix = int'(a) - int'(BASE);
    bit iw = (a >= BASE) && (ix < NL);
    logic [1:0] so = iw ? mdl[ix][ot] : 2'd0;
    bit rd = (o == 2'd0) || (o == 2'd3);
    bit own = (o == 2'd1);
    bit ev = (o == 2'd2);
    bit nosn = use_n && (ot == 1);
    bit esn = iw && ((rd && so == 2'd2) || (own && so != 2'd0));
    bit efetch = esn && !nosn && so == 2'd2;
    bit got = 1'b0, done = 1'b0;
    string tag = !iw ? "R1" : ev ? "R8" : rd ? "R3" : (so == 2'd2) ? "R6" : "R5";
    string dtag = (own && so == 2'd2) ? "R6" : "R4";
    req[b] = 1'b1; op[b] = o; addr[b] = a; wd[b] = w;
    for (int c = 0; c < 30 && !done; c++) begin
      @(negedge clk);
      if (sreq[b]) chk({tag, " snoop to requester"}, 1, 0);
      if (sreq[ot] && !got) begin
        got = 1'b1;
        chk({tag, " snoop invalidate"}, int'(sinv[ot]), int'(own));
        chk({tag, " snoop addr"}, int'(sadr), int'(a));
        sack[ot] = 1'b1; sdat[ot] = s;
      end else if (ack[b]) begin
        done = 1'b1;
        sack = '0; req[b] = 1'b0;
        chk({tag, " snoop issued"}, int'(got), int'(esn && !nosn));
        chk("R7 shared", int'(sh[b]), int'(iw && rd));
        chk({dtag, " hit"}, int'(hit[b]), int'(efetch));
        if (efetch) begin
          chk({dtag, " hit data"}, int'(hd), int'(s));
          chk({dtag, " writeback data"}, int'(mwd), int'(s));
        end
        chk("R11 mem strobe", int'(mreq), 1);
        chk({tag, " mem write"}, int'(mwe), int'(ev || efetch));
        chk("R1 mem addr", int'(madr), int'(a));
        if (ev) chk("R8 eviction data", int'(mwd), int'(w));
        chk("R10 irq", int'(irq[ot]), int'(esn && nosn));
        chk("R10 irq self", int'(irq[b]), 0);
        if (got) chk("R11 snoop latency", c, 1); else chk("R11 ack latency", c, 0);
      end
    end
    if (!done) begin
      chk("R11 ack timeout", 0, 1);
      req[b] = 1'b0; sack = '0;
    end
    if (iw) begin
      if (ev) mdl[ix][b] = 2'd0;
      else if (own) begin mdl[ix][b] = 2'd2; mdl[ix][ot] = 2'd0; end
      else begin mdl[ix][b] = 2'd1; if (so == 2'd2) mdl[ix][ot] = 2'd1; end
    end
    @(negedge clk);
  endtask

  task automatic step();
    rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
  endtask

  task automatic sweep(int n);
    for (int k = 0; k < n; k++) begin
      step();
      txn(int'(rnd[0]), rnd[2:1], 8'h3C + 8'(rnd[15:8] % 20), rnd[23:16], rnd[31:24]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11: got hang exp completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    for (int l = 0; l < NL; l++) txn(l % 2, 2'd0, BASE + 8'(l), 8'h00, 8'hEE);
    sweep(700);

    // R9: same-cycle requests to one line
    do_reset();
    req = 2'b11; op[0] = 2'd1; addr[0] = 8'h42; op[1] = 2'd0; addr[1] = 8'h42;
    @(negedge clk);
    chk("R9 bus0 first", {30'd0, ack}, 1);
    chk("R9 ownership not shared", {30'd0, sh}, 0);
    req[0] = 1'b0;
    @(negedge clk);
    chk("R9 bus1 stalled", {28'd0, ack, sreq}, 0);
    @(negedge clk);
    chk("R9 bus1 sees update", {30'd0, sreq}, 1);
    chk("R9 fetch kind", {30'd0, sinv}, 0);
    sack[0] = 1'b1; sdat[0] = 8'h5A;
    @(negedge clk);
    chk("R9 bus1 ack", {30'd0, ack}, 2);
    chk("R9 hit", {30'd0, hit}, 2);
    chk("R9 hit data", int'(hd), 8'h5A);
    chk("R9 shared", {30'd0, sh}, 2);
    sack = '0; req[1] = 1'b0;
    mdl[2][0] = 2'd1; mdl[2][1] = 2'd1;
    @(negedge clk);
    txn(0, 2'd1, 8'h42, 8'h00, 8'h11);
    txn(1, 2'd2, 8'h43, 8'h77, 8'h00);
    txn(0, 2'd1, 8'h43, 8'h00, 8'h22);

    // R10: bus 1 cannot be snooped
    use_n = 1'b1;
    do_reset();
    txn(1, 2'd1, 8'h45, 8'h00, 8'h33);
    txn(0, 2'd0, 8'h45, 8'h00, 8'h34);
    txn(1, 2'd0, 8'h46, 8'h00, 8'h35);
    txn(0, 2'd1, 8'h46, 8'h00, 8'h36);
    txn(1, 2'd1, 8'h46, 8'h00, 8'h37);
    sweep(200);

    summary();
    $finish;
  end
endmodule